// File: doc/BRIEF.md
# USB Host Controller Register File

This block holds the software-visible registers of a host controller for a USB bus of the classic frame-list kind. Software reaches it through a 32-bit register bus with byte strobes. A frame engine outside the block raises completion and error events into it. Device attach and detach indications arrive for each root-hub port. The block keeps the command, status, interrupt-enable, frame-number and frame-list-base registers and one control/status register per port. From these it drives a level interrupt and one-cycle pulses that start the schedule, reset the controller, reset the whole bus or reset the device on one port.

Run control is a two-state machine. In `RUN_HALTED` the controller is stopped: the halted status bit reads 1 and the frame number may be written. Transition `start` (a command write with run/stop = 1) moves it to `RUN_ACTIVE` and fires the schedule-start pulse. In `RUN_ACTIVE` the frame number is frozen. Transition `stop` (a command write with run/stop = 0) or transition `hc_reset` (a command write with bit 1 set) returns it to `RUN_HALTED`.

A hidden two-bit cause latch records whether the pending USB interrupt came from a completion (bit 0) or from a short packet (bit 1). Each cause has its own enable. The latch cannot be read.

Top module: `usb_hc_regs`

## Requirements
- R1: After reset, dword 0 reads 0x0020_0000, meaning the status register holds only halted (bit 5) and the command is 0. The interrupt enable, frame number, frame-list base and all port registers read 0, and irq is low.
- R2: The address is a dword index. Dword 0 holds the command in [15:0] and the status in [31:16]. Dword 1 holds the interrupt enable in [15:0] and the frame number in [31:16]. Dword 2 is the frame-list base, dword 3 reads 0, and dword 4+k holds port 2k in [15:0] and port 2k+1 in [31:16]. A 16-bit register is written when either of its byte strobes is set; a byte whose strobe is clear keeps its old value.
- R3: Command bit 0 is run/stop. Writing 1 while halted enters `RUN_ACTIVE`, clears status bit 5 and pulses sched_start_o for one cycle. Writing 0 enters `RUN_HALTED` and sets bit 5.
- R4: Writing command bit 1 pulses hc_reset_o. From the next cycle every register is back at its R1 value, and this takes priority over every other write or event in that cycle.
- R5: Writing command bit 2 (without bit 1) stores the bit and pulses global_reset_o. In the same cycle it pulses port_bus_reset_o for every port whose connect bit (bit 0) is set.
- R6: The event inputs set status bits: ev_ioc_i and ev_short_i set bit 0 and cause latch bits 0 and 1 respectively; ev_err_i sets bit 1; ev_resume_i bit 2; ev_hse_i bit 3; ev_perr_i bit 4. Writing 1 to one of these status bits clears it. Writing 1 to bit 0 also clears both cause latch bits. An event wins over a clear in the same cycle.
- R7: The frame number (11 bits) accepts a write only in `RUN_HALTED`. Bits above bit 10 are dropped.
- R8: The frame-list base stores the written value with bits [11:0] forced to 0.
- R9: irq_o is high when any of these holds: cause bit 0 and enable bit 2; cause bit 1 and enable bit 3; status bit 1 and enable bit 0; status bit 2 and enable bit 1; status bit 3; status bit 4.
- R10: On a port write, the bits under mask 0x01FB keep their old value and the other bits take the written value. After that, bits 1 (connect change) and 3 (enable change) are cleared where a 1 was written.
- R11: A port write that takes bit 9 from 0 to 1 on a connected port pulses that port's port_bus_reset_o.
- R12: On attach, a port whose bit 0 is clear gets bits 0 and 1 set, and bit 8 follows dev_lowspd_i. On detach, a set bit 0 is cleared and bit 1 is set. A set bit 2 (enabled) is cleared and bit 3 is set. Both are applied after a port write in the same cycle, and detach after attach.
- R13: A port slot at or above NPORTS reads 0xFF7F and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 3 | Dword index of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_be_i | input | 4 | Byte strobes of the write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed dword (combinational) |
| ev_ioc_i | input | 1 | Completion-with-interrupt event |
| ev_short_i | input | 1 | Short-packet event |
| ev_err_i | input | 1 | Transfer error event |
| ev_resume_i | input | 1 | Resume detected |
| ev_hse_i | input | 1 | Host system error |
| ev_perr_i | input | 1 | Schedule process error |
| dev_attach_i | input | NPORTS | Device attached, one per port |
| dev_detach_i | input | NPORTS | Device detached, one per port |
| dev_lowspd_i | input | NPORTS | Attached device is low speed |
| irq_o | output | 1 | Level interrupt |
| sched_start_o | output | 1 | Start schedule processing |
| hc_reset_o | output | 1 | Controller reset pulse |
| global_reset_o | output | 1 | Whole-bus reset pulse |
| port_bus_reset_o | output | NPORTS | Per-port device reset pulse |

## Verification
The bench builds the block with NPORTS = 3, an odd count. Port 2 then sits alone in the low half of dword 5, its upper half is an absent slot, and dwords 6 and 7 are fully absent. This exercises both R13 and the half-dword write decode at the edge of the implemented ports. A directed pass then covers the run states, each interrupt cause against its enable, and the port change bits. A long stretch of mixed-strobe writes, events and attach/detach traffic follows.

// File: rtl/usb_hcr_pkg.sv
package usb_hcr_pkg;

    typedef enum logic {
        RUN_HALTED = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    localparam int unsigned PORT_SLOTS = 8;
    localparam logic [2:0] DW_CMD_STS = 3'd0;
    localparam logic [2:0] DW_EN_FRM  = 3'd1;
    localparam logic [2:0] DW_FLBASE  = 3'd2;
    localparam int unsigned DW_PORT0  = 4;

    localparam logic [15:0] PORT_KEEP_MASK = 16'h01FB;
    localparam logic [15:0] PORT_W1C_MASK  = 16'h000A;
    localparam logic [15:0] PORT_ABSENT    = 16'hFF7F;

    localparam int unsigned PB_CONN     = 0;
    localparam int unsigned PB_CONN_CHG = 1;
    localparam int unsigned PB_EN       = 2;
    localparam int unsigned PB_EN_CHG   = 3;
    localparam int unsigned PB_LOWSPD   = 8;
    localparam int unsigned PB_BUSRST   = 9;

    function automatic logic [15:0] merge16(input logic [15:0] old,
                                            input logic [15:0] wd,
                                            input logic [1:0]  be);
        return {be[1] ? wd[15:8] : old[15:8], be[0] ? wd[7:0] : old[7:0]};
    endfunction

    function automatic logic [15:0] strobe16(input logic [15:0] wd,
                                             input logic [1:0]  be);
        return wd & {{8{be[1]}}, {8{be[0]}}};
    endfunction

endpackage

// File: rtl/usb_hcr_runctl.sv
module usb_hcr_runctl
    import usb_hcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic rs_new,
    input  logic hc_rst,
    output logic halted_o,
    output logic sched_start_o
);

    run_state_e state_q, state_d;
    logic start_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALTED: if (!hc_rst && cmd_we && rs_new) state_d = RUN_ACTIVE;
            RUN_ACTIVE: if (hc_rst || (cmd_we && !rs_new)) state_d = RUN_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_HALTED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= (state_q == RUN_HALTED) && (state_d == RUN_ACTIVE);
    end

    assign halted_o      = (state_q == RUN_HALTED);
    assign sched_start_o = start_q;

    a_r3_start_leaves_halt: assert property (@(posedge clk) disable iff (!rst_n)
        sched_start_o |-> !halted_o);

endmodule

// File: rtl/usb_hcr_port.sv
module usb_hcr_port
    import usb_hcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        we,
    input  logic [15:0] wv,
    input  logic [15:0] wc,
    input  logic        attach,
    input  logic        detach,
    input  logic        low_speed,
    input  logic        greset,
    output logic [15:0] val_o,
    output logic        bus_reset_o
);

    logic [15:0] val_q, val_d;
    logic        rst_q;

    always_comb begin
        val_d = val_q;
        if (we) begin
            val_d = (val_q & PORT_KEEP_MASK) | (wv & ~PORT_KEEP_MASK);
            val_d = val_d & ~(wc & PORT_W1C_MASK);
        end
        if (attach) begin
            if (!val_d[PB_CONN]) begin
                val_d[PB_CONN]     = 1'b1;
                val_d[PB_CONN_CHG] = 1'b1;
            end
            val_d[PB_LOWSPD] = low_speed;
        end
        if (detach) begin
            if (val_d[PB_CONN]) begin
                val_d[PB_CONN]     = 1'b0;
                val_d[PB_CONN_CHG] = 1'b1;
            end
            if (val_d[PB_EN]) begin
                val_d[PB_EN]     = 1'b0;
                val_d[PB_EN_CHG] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            val_q <= '0;
            rst_q <= 1'b0;
        end else begin
            val_q <= val_d;
            rst_q <= val_q[PB_CONN] &&
                     ((we && wv[PB_BUSRST] && !val_q[PB_BUSRST]) || greset);
        end
    end

    assign val_o       = val_q;
    assign bus_reset_o = rst_q;

    a_r11_reset_needs_connect: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_o |-> $past(val_q[PB_CONN]));

    a_r10_change_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wc[PB_CONN_CHG] && !attach && !detach && !clr) |=> !val_q[PB_CONN_CHG]);

    a_r12_attach_connects: assert property (@(posedge clk) disable iff (!rst_n)
        (attach && !detach && !clr) |=> val_q[PB_CONN]);

endmodule

// File: rtl/usb_hcr_irq.sv
module usb_hcr_irq (
    input  logic [1:0] cause,
    input  logic [4:0] sts,
    input  logic [3:0] ien,
    output logic       irq_o
);

    logic [5:0] src;

    always_comb begin
        src[0] = cause[0] & ien[2];
        src[1] = cause[1] & ien[3];
        src[2] = sts[1]   & ien[0];
        src[3] = sts[2]   & ien[1];
        src[4] = sts[3];
        src[5] = sts[4];
    end

    assign irq_o = |src;

endmodule

// File: rtl/usb_hc_regs.sv
module usb_hc_regs
    import usb_hcr_pkg::*;
#(
    parameter int unsigned NPORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [3:0]        bus_be_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              ev_ioc_i,
    input  logic              ev_short_i,
    input  logic              ev_err_i,
    input  logic              ev_resume_i,
    input  logic              ev_hse_i,
    input  logic              ev_perr_i,
    input  logic [NPORTS-1:0] dev_attach_i,
    input  logic [NPORTS-1:0] dev_detach_i,
    input  logic [NPORTS-1:0] dev_lowspd_i,
    output logic              irq_o,
    output logic              sched_start_o,
    output logic              hc_reset_o,
    output logic              global_reset_o,
    output logic [NPORTS-1:0] port_bus_reset_o
);

    logic [2:0]  cmd_q;
    logic [4:0]  sts_q, sts_d;
    logic [1:0]  cause_q, cause_d;
    logic [3:0]  ien_q;
    logic [10:0] frm_q;
    logic [31:0] base_q;
    logic        hcr_q, grst_q, halted;

    logic        we_cmd, we_sts, we_ien, we_frm, we_base;
    logic [2:0]  cmd_v;
    logic        hc_rst, greset;
    logic [4:0]  sts_clr;

    assign we_cmd  = bus_wr_i && (bus_addr_i == DW_CMD_STS) && (|bus_be_i[1:0]);
    assign we_sts  = bus_wr_i && (bus_addr_i == DW_CMD_STS) && bus_be_i[2];
    assign we_ien  = bus_wr_i && (bus_addr_i == DW_EN_FRM)  && bus_be_i[0];
    assign we_frm  = bus_wr_i && (bus_addr_i == DW_EN_FRM)  && (|bus_be_i[3:2]);
    assign we_base = bus_wr_i && (bus_addr_i == DW_FLBASE)  && (|bus_be_i);

    assign cmd_v   = bus_be_i[0] ? bus_wdata_i[2:0] : cmd_q;
    assign hc_rst  = we_cmd && cmd_v[1];
    assign greset  = we_cmd && cmd_v[2] && !hc_rst;
    assign sts_clr = we_sts ? bus_wdata_i[20:16] : 5'b0;

    always_comb begin
        sts_d      = sts_q & ~sts_clr;
        cause_d    = cause_q & ~{2{sts_clr[0]}};
        sts_d[0]   = sts_d[0] | ev_ioc_i | ev_short_i;
        sts_d[1]   = sts_d[1] | ev_err_i;
        sts_d[2]   = sts_d[2] | ev_resume_i;
        sts_d[3]   = sts_d[3] | ev_hse_i;
        sts_d[4]   = sts_d[4] | ev_perr_i;
        cause_d    = cause_d | {ev_short_i, ev_ioc_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || hc_rst) begin
            cmd_q   <= '0;
            sts_q   <= '0;
            cause_q <= '0;
            ien_q   <= '0;
            frm_q   <= '0;
            base_q  <= '0;
        end else begin
            if (we_cmd) cmd_q <= cmd_v;
            sts_q   <= sts_d;
            cause_q <= cause_d;
            if (we_ien) ien_q <= bus_wdata_i[3:0];
            if (we_frm && halted)
                frm_q <= {bus_be_i[3] ? bus_wdata_i[26:24] : frm_q[10:8],
                          bus_be_i[2] ? bus_wdata_i[23:16] : frm_q[7:0]};
            if (we_base)
                base_q <= {bus_be_i[3] ? bus_wdata_i[31:24] : base_q[31:24],
                           bus_be_i[2] ? bus_wdata_i[23:16] : base_q[23:16],
                           bus_be_i[1] ? bus_wdata_i[15:12] : base_q[15:12],
                           12'h000};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcr_q  <= 1'b0;
            grst_q <= 1'b0;
        end else begin
            hcr_q  <= hc_rst;
            grst_q <= greset;
        end
    end

    usb_hcr_runctl u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (we_cmd),
        .rs_new       (cmd_v[0]),
        .hc_rst       (hc_rst),
        .halted_o     (halted),
        .sched_start_o(sched_start_o)
    );

    usb_hcr_irq u_irq (
        .cause(cause_q),
        .sts  (sts_q),
        .ien  (ien_q),
        .irq_o(irq_o)
    );

    logic [15:0] port_val [NPORTS];
    logic [15:0] slot     [PORT_SLOTS];

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        localparam logic [2:0]  PDW = 3'(DW_PORT0 + i / 2);
        localparam int unsigned HB  = 16 * (i % 2);
        localparam int unsigned BB  = 2 * (i % 2);
        logic        p_we;
        logic [15:0] p_wv, p_wc;

        assign p_we = bus_wr_i && (bus_addr_i == PDW) && (|bus_be_i[BB +: 2]);
        assign p_wv = merge16(port_val[i], bus_wdata_i[HB +: 16], bus_be_i[BB +: 2]);
        assign p_wc = p_we ? strobe16(bus_wdata_i[HB +: 16], bus_be_i[BB +: 2]) : 16'h0;

        usb_hcr_port u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (hc_rst),
            .we         (p_we),
            .wv         (p_wv),
            .wc         (p_wc),
            .attach     (dev_attach_i[i]),
            .detach     (dev_detach_i[i]),
            .low_speed  (dev_lowspd_i[i]),
            .greset     (greset),
            .val_o      (port_val[i]),
            .bus_reset_o(port_bus_reset_o[i])
        );
    end

    for (genvar s = 0; s < PORT_SLOTS; s++) begin : g_slot
        if (s < NPORTS) begin : g_live
            assign slot[s] = port_val[s];
        end else begin : g_absent
            assign slot[s] = PORT_ABSENT;
        end
    end

    always_comb begin
        case (bus_addr_i)
            3'd0:    bus_rdata_o = {10'b0, halted, sts_q, 13'b0, cmd_q};
            3'd1:    bus_rdata_o = {5'b0, frm_q, 12'b0, ien_q};
            3'd2:    bus_rdata_o = base_q;
            3'd4:    bus_rdata_o = {slot[1], slot[0]};
            3'd5:    bus_rdata_o = {slot[3], slot[2]};
            3'd6:    bus_rdata_o = {slot[5], slot[4]};
            3'd7:    bus_rdata_o = {slot[7], slot[6]};
            default: bus_rdata_o = 32'h0;
        endcase
    end

    assign hc_reset_o     = hcr_q;
    assign global_reset_o = grst_q;

    a_r7_frame_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !hc_rst) |=> $stable(frm_q));

    a_r9_hse_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_hse_i && !hc_rst) |=> irq_o);

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (we_sts && bus_wdata_i[16] && !ev_ioc_i && !ev_short_i) |=> (sts_q[0] == 1'b0));

    a_r4_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        hc_rst |=> (ien_q == 4'h0 && frm_q == 11'h0 && halted && hc_reset_o));

    a_r5_global_not_hcr: assert property (@(posedge clk) disable iff (!rst_n)
        global_reset_o |-> !hc_reset_o);

endmodule

// File: tb/sim_usb_hc_regs.sv
module sim_usb_hc_regs;

    localparam int NP = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [2:0]    a;
    logic          wr;
    logic [3:0]    be;
    logic [31:0]   wd;
    logic          e_ioc, e_spd, e_err, e_rd, e_hse, e_pe;
    logic [NP-1:0] att, det, ls;

    logic [31:0]   rdata;
    logic          irq, sched, hcr, grst;
    logic [NP-1:0] pbr;

    usb_hc_regs #(.NPORTS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(a), .bus_wr_i(wr), .bus_be_i(be),
        .bus_wdata_i(wd), .bus_rdata_o(rdata), .ev_ioc_i(e_ioc), .ev_short_i(e_spd),
        .ev_err_i(e_err), .ev_resume_i(e_rd), .ev_hse_i(e_hse), .ev_perr_i(e_pe),
        .dev_attach_i(att), .dev_detach_i(det), .dev_lowspd_i(ls), .irq_o(irq),
        .sched_start_o(sched), .hc_reset_o(hcr), .global_reset_o(grst),
        .port_bus_reset_o(pbr)
    );

    // reference model state
    logic [2:0]    m_cmd;
    logic [4:0]    m_sts;
    logic [1:0]    m_cause;
    logic [3:0]    m_ien;
    logic [10:0]   m_frm;
    logic [31:0]   m_base;
    logic [15:0]   m_port [NP];
    logic          m_halt, m_sched, m_hcr, m_grst;
    logic [NP-1:0] m_pbr;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";

    function automatic logic [15:0] m_slot(int idx);
        return (idx < NP) ? m_port[idx] : 16'hFF7F;
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] dw);
        case (dw)
            3'd0:    return {10'b0, m_halt, m_sts, 13'b0, m_cmd};
            3'd1:    return {5'b0, m_frm, 12'b0, m_ien};
            3'd2:    return m_base;
            3'd3:    return 32'h0;
            default: return {m_slot(2 * (int'(dw) - 4) + 1), m_slot(2 * (int'(dw) - 4))};
        endcase
    endfunction

    function automatic logic m_irq();
        return (m_cause[0] && m_ien[2]) || (m_cause[1] && m_ien[3]) ||
               (m_sts[1] && m_ien[0]) || (m_sts[2] && m_ien[1]) || m_sts[3] || m_sts[4];
    endfunction

    task automatic model_reset();
        m_cmd = 0; m_sts = 0; m_cause = 0; m_ien = 0; m_frm = 0; m_base = 0;
        m_halt = 1; m_pbr = 0;
        for (int i = 0; i < NP; i++) m_port[i] = 16'h0;
    endtask

    task automatic model_step();
        logic [31:0] cur, mix, clrm;
        logic        hit_cmd, do_hcr, h_old, conn_old;
        logic [15:0] old, np, v, c;
        if (!rst_n) begin
            model_reset();
            m_sched = 0; m_hcr = 0; m_grst = 0;
            return;
        end
        cur = m_read(a);
        for (int b = 0; b < 4; b++) begin
            mix[8*b +: 8]  = be[b] ? wd[8*b +: 8] : cur[8*b +: 8];
            clrm[8*b +: 8] = be[b] ? wd[8*b +: 8] : 8'h00;
        end
        hit_cmd = wr && a == 3'd0 && (be[0] || be[1]);
        do_hcr  = hit_cmd && mix[1];
        m_hcr   = do_hcr;
        m_grst  = hit_cmd && mix[2] && !do_hcr;
        m_sched = hit_cmd && mix[0] && m_halt && !do_hcr;
        if (do_hcr) begin
            model_reset();
            return;
        end
        h_old = m_halt;
        // ports first, using old connect state
        for (int i = 0; i < NP; i++) begin
            logic pw;
            old = m_port[i];
            pw  = wr && (int'(a) == 4 + i / 2) && (be[2*(i%2)] || be[2*(i%2)+1]);
            v   = mix[16*(i%2) +: 16];
            c   = clrm[16*(i%2) +: 16];
            conn_old = old[0];
            m_pbr[i] = conn_old && ((pw && v[9] && !old[9]) || m_grst);
            np = old;
            if (pw) begin
                np = (old & 16'h01FB) | (v & ~16'h01FB);
                np = np & ~(c & 16'h000A);
            end
            if (att[i]) begin
                if (!np[0]) np[1:0] = 2'b11;
                np[8] = ls[i];
            end
            if (det[i]) begin
                if (np[0]) begin np[0] = 0; np[1] = 1; end
                if (np[2]) begin np[2] = 0; np[3] = 1; end
            end
            m_port[i] = np;
        end
        if (hit_cmd) begin
            m_cmd  = mix[2:0];
            m_halt = !mix[0];
        end
        if (wr && a == 3'd0 && be[2]) begin
            m_sts   = m_sts & ~wd[20:16];
            if (wd[16]) m_cause = 2'b00;
        end
        if (e_ioc) begin m_sts[0] = 1; m_cause[0] = 1; end
        if (e_spd) begin m_sts[0] = 1; m_cause[1] = 1; end
        if (e_err) m_sts[1] = 1;
        if (e_rd)  m_sts[2] = 1;
        if (e_hse) m_sts[3] = 1;
        if (e_pe)  m_sts[4] = 1;
        if (wr && a == 3'd1 && be[0]) m_ien = wd[3:0];
        if (wr && a == 3'd1 && (be[2] || be[3]) && h_old) m_frm = mix[26:16];
        if (wr && a == 3'd2 && be != 4'b0) m_base = mix & 32'hFFFF_F000;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #2;
        if (rst_n) begin
            chk({phase, " rdata"}, rdata, m_read(a));
            chk("R9 irq", {31'b0, irq}, {31'b0, m_irq()});
            chk("R3 sched_start", {31'b0, sched}, {31'b0, m_sched});
            chk("R4 hc_reset", {31'b0, hcr}, {31'b0, m_hcr});
            chk("R5 global_reset", {31'b0, grst}, {31'b0, m_grst});
            chk("R11 port_bus_reset", {{(32-NP){1'b0}}, pbr}, {{(32-NP){1'b0}}, m_pbr});
        end
    end

    task automatic idle_inputs();
        wr = 0; be = 0; wd = 0;
        e_ioc = 0; e_spd = 0; e_err = 0; e_rd = 0; e_hse = 0; e_pe = 0;
        att = 0; det = 0;
    endtask

    task automatic drive_wr(logic [2:0] dw, logic [3:0] b, logic [31:0] d);
        @(negedge clk);
        a = dw; wr = 1; be = b; wd = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic look(logic [2:0] dw);
        @(negedge clk);
        a = dw;
        @(negedge clk);
    endtask

    task automatic port_ev(int p, logic at, logic dt, logic low);
        @(negedge clk);
        att[p] = at; det[p] = dt; ls[p] = low;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; a = 0; ls = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        phase = "R1";
        chk("R1 status/command", rdata, 32'h0020_0000);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        look(3'd4);
        chk("R1 ports", rdata, 32'h0);

        phase = "R8";
        drive_wr(3'd2, 4'hF, 32'hFFFF_FFFF);
        chk("R8 base", rdata, 32'hFFFF_F000);

        phase = "R7";
        drive_wr(3'd1, 4'b1100, 32'hFFFF_0000);
        chk("R7 frame halted", rdata, 32'h07FF_0000);

        phase = "R3";
        drive_wr(3'd0, 4'b0001, 32'h1);
        chk("R3 start pulse", {31'b0, sched}, 32'h1);
        chk("R3 running", rdata, 32'h0000_0001);
        phase = "R7";
        drive_wr(3'd1, 4'b1100, 32'h0123_0000);
        chk("R7 frame locked", rdata, 32'h07FF_0000);
        phase = "R3";
        drive_wr(3'd0, 4'b0001, 32'h0);
        chk("R3 halted again", rdata, 32'h0020_0000);

        phase = "R2";
        drive_wr(3'd2, 4'b0100, 32'h00AB_0000);
        chk("R2 byte lane", rdata, 32'hFFAB_F000);
        drive_wr(3'd3, 4'hF, 32'hFFFF_FFFF);
        chk("R2 reserved", rdata, 32'h0);

        phase = "R9";
        drive_wr(3'd1, 4'b0001, 32'h0);
        @(negedge clk); e_ioc = 1; @(negedge clk); idle_inputs();
        chk("R9 ioc masked", {31'b0, irq}, 32'h0);
        drive_wr(3'd1, 4'b0001, 32'h4);
        chk("R9 ioc enabled", {31'b0, irq}, 32'h1);
        phase = "R6";
        drive_wr(3'd0, 4'b0100, 32'h0001_0000);
        chk("R6 ack", rdata, 32'h0020_0000);
        chk("R6 latch cleared", {31'b0, irq}, 32'h0);
        @(negedge clk); e_spd = 1; @(negedge clk); idle_inputs();
        chk("R9 short needs bit3", {31'b0, irq}, 32'h0);
        drive_wr(3'd1, 4'b0001, 32'h8);
        chk("R9 short enabled", {31'b0, irq}, 32'h1);
        drive_wr(3'd0, 4'b0100, 32'h0001_0000);
        drive_wr(3'd1, 4'b0001, 32'h0);
        @(negedge clk); e_hse = 1; e_err = 1; @(negedge clk); idle_inputs();
        chk("R9 hse no enable", {31'b0, irq}, 32'h1);
        drive_wr(3'd0, 4'b0100, 32'h0008_0000);
        chk("R6 err masked", {31'b0, irq}, 32'h0);
        @(negedge clk); a = 3'd0; wr = 1; be = 4'b0100; wd = 32'h0002_0000; e_err = 1;
        @(negedge clk); idle_inputs();
        chk("R6 event wins", rdata, 32'h0022_0000);
        drive_wr(3'd0, 4'b0100, 32'h001F_0000);

        phase = "R12";
        port_ev(0, 1, 0, 1);
        look(3'd4);
        chk("R12 attach low speed", rdata, 32'h0000_0103);
        phase = "R10";
        drive_wr(3'd4, 4'b0011, 32'h0000_FFFF);
        chk("R11 bit9 rise", {{(32-NP){1'b0}}, pbr}, 32'h1);
        chk("R10 masked write", rdata, 32'h0000_FF05);
        drive_wr(3'd4, 4'b0011, 32'h0);
        chk("R10 keep bits", rdata, 32'h0000_0101);
        drive_wr(3'd4, 4'b0001, 32'h4);
        phase = "R12";
        port_ev(0, 0, 1, 0);
        chk("R12 detach", rdata, 32'h0000_010A);

        phase = "R5";
        port_ev(2, 1, 0, 0);
        port_ev(0, 1, 0, 0);
        chk("R12 reattach", rdata, 32'h0000_000B);
        drive_wr(3'd0, 4'b0001, 32'h4);
        chk("R5 global pulse", {31'b0, grst}, 32'h1);
        chk("R5 connected ports", {{(32-NP){1'b0}}, pbr}, 32'h5);
        chk("R5 stored", rdata, 32'h0020_0004);
        drive_wr(3'd0, 4'b0001, 32'h0);

        phase = "R13";
        drive_wr(3'd5, 4'hF, 32'hFFFF_0000);
        chk("R13 absent half", rdata, 32'hFF7F_0003);
        look(3'd7);
        chk("R13 absent dword", rdata, 32'hFF7F_FF7F);

        phase = "R4";
        drive_wr(3'd0, 4'b0001, 32'h3);
        chk("R4 pulse", {31'b0, hcr}, 32'h1);
        chk("R4 defaults", rdata, 32'h0020_0000);
        look(3'd4);
        chk("R4 ports cleared", rdata, 32'h0);

        phase = "R2";
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            a  = 3'($urandom_range(0, 7));
            wr = ($urandom_range(0, 2) == 0);
            be = 4'($urandom);
            wd = $urandom;
            if (a == 3'd0 && $urandom_range(0, 60) != 0) wd[1] = 1'b0;
            e_ioc = ($urandom_range(0, 15) == 0);
            e_spd = ($urandom_range(0, 15) == 0);
            e_err = ($urandom_range(0, 15) == 0);
            e_rd  = ($urandom_range(0, 15) == 0);
            e_hse = ($urandom_range(0, 40) == 0);
            e_pe  = ($urandom_range(0, 40) == 0);
            for (int p = 0; p < NP; p++) begin
                att[p] = ($urandom_range(0, 10) == 0);
                det[p] = ($urandom_range(0, 12) == 0);
                ls[p]  = 1'($urandom);
            end
        end
        @(negedge clk);
        idle_inputs();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule